// File: doc/BRIEF.md
# Pulse-Programmed OTP Parameter Controller

This block programs a small set of parameter registers using nothing more than pulses on a supply pin. An analog front end outside the block sorts the pin levels and delivers three clean strobes, each one clock wide: a mid-level step, a high-level advance and a fuse-blow request. The block also receives a power-on reset and a factory initialisation. A high-level pulse moves a selection state machine around a fixed loop: PH_MODE (pick a mode key), then PH_REG (pick a register), then PH_BIT (pick a code), then back to PH_MODE. Mid-level pulses count the key or code that belongs to the current state.

Mode key 1 selects blow mode. In blow mode a blow request permanently sets exactly one fuse bit, the bit addressed by a one-hot code. A multi-bit value is built up from several blows, and the bits accumulate by OR. Register 3 is the lock fuse. Mode key 2 selects try mode. In try mode each step of the code is applied to the selected parameter at once, in a volatile register that holds until the next power-on reset.

Three 3-bit parameters are presented packed on one output. Each one shows its trial value if it was tried since the last power-on, and its fuse value otherwise.

Transitions: T_ADV_REG (PH_MODE to PH_REG on high), T_ADV_BIT (PH_REG to PH_BIT on high), T_WRAP (PH_BIT to PH_MODE on high, which clears all three counters), T_STEP (mid pulse, no state change), T_POR (any state to PH_MODE on power-on reset).

Top module: `otp_pulse_prog`

## Requirements
- R1: `phase` is encoded PH_MODE=0, PH_REG=1, PH_BIT=2 and never takes the value 3. Each `high_pulse` advances it 0→1→2→0. Wrapping from 2 to 0 clears the mode, register and code counters.
- R2: Each `mid_pulse` increments the counter of the current phase by one. The counters saturate at these limits: mode key at 2, register select at 3, code at 7.
- R3: In try mode (mode key 2), each mid pulse in PH_BIT with register select 0..2 writes the new code as that parameter's trial value. The value appears on `eff_val[3r+2:3r]` in the cycle after the pulse. From then until power-on reset, that slice shows the trial value instead of the fuse value.
- R4: In blow mode (mode key 1), a `blow_req` in PH_BIT with a one-hot code ORs the code into the fuse of the selected register (0..2). With register 3 selected, it sets `locked` instead.
- R5: A `blow_req` that would otherwise be accepted but carries a nonzero code that is not one-hot raises `blow_err` for exactly the following cycle and changes no fuse.
- R6: A `blow_req` is ignored without error in four cases: code 0, mode key other than 1, phase other than PH_BIT, or `locked` set.
- R7: Fuse bits are never cleared. The final value is the OR of all accepted blows, whatever their order, and blowing a bit a second time changes nothing.
- R8: Taking `por_n` low returns the phase to PH_MODE and clears the counters and all trial values. Fuses and the lock are kept, so `eff_val` reverts to the fuse values.
- R9: While `locked` is set, blows and try-mode writes have no effect on any parameter.
- R10: When several strobes arrive in the same cycle, `high_pulse` alone is acted on. Otherwise `mid_pulse` takes precedence over `blow_req`.
- R11: Taking `fuse_init_n` low models the unprogrammed part: it clears the fuses, the lock, and all volatile state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| fuse_init_n | input | 1 | Factory initialisation, active low, synchronous |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| mid_pulse | input | 1 | Mid-level pulse strobe |
| high_pulse | input | 1 | High-level pulse strobe |
| blow_req | input | 1 | Fuse blow request strobe |
| phase | output | 2 | Current selection phase |
| eff_val | output | 9 | Effective parameter values, 3 bits per register |
| locked | output | 1 | Lock fuse state |
| blow_err | output | 1 | One-cycle flag for a rejected non-one-hot blow |

## Verification
A wrong phase or a wrong counter shows up one pulse later. The next mid step lands on the wrong trial slice or writes the wrong value, so `eff_val` differs in the cycle after that step. Corruption in the fuse bank is visible at once on the selected slice, and after any power-on reset it is visible on every slice. The lock, error flag and wrapping rules each show at the ports within one cycle of the strobe that exercises them.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
    typedef enum logic [1:0] {
        PH_MODE = 2'd0,
        PH_REG  = 2'd1,
        PH_BIT  = 2'd2
    } phase_e;

    localparam logic [1:0] MODE_BLOW = 2'd1;
    localparam logic [1:0] MODE_TRY  = 2'd2;
    localparam logic [1:0] MODE_MAX  = 2'd2;
endpackage

// File: rtl/otp_sel_fsm.sv
module otp_sel_fsm
    import otp_prog_pkg::*;
#(
    parameter int W    = 3,
    parameter int NREG = 3,
    localparam int RW  = $clog2(NREG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mid,
    input  logic          high,
    output phase_e        phase_o,
    output logic [1:0]    mode_o,
    output logic [RW-1:0] sel_o,
    output logic [W-1:0]  code_o,
    output logic          code_step_o,
    output logic [W-1:0]  code_next_o
);
    localparam logic [RW-1:0] SEL_MAX = RW'(NREG);

    phase_e        state_q, state_d;
    logic [1:0]    mode_q, mode_d;
    logic [RW-1:0] sel_q, sel_d;
    logic [W-1:0]  code_q, code_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_MODE;
            mode_q  <= '0;
            sel_q   <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            sel_q   <= sel_d;
            code_q  <= code_d;
        end
    end

    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        sel_d   = sel_q;
        code_d  = code_q;
        if (high) begin
            unique case (state_q)
                PH_MODE: state_d = PH_REG;
                PH_REG:  state_d = PH_BIT;
                PH_BIT: begin
                    state_d = PH_MODE;
                    mode_d  = '0;
                    sel_d   = '0;
                    code_d  = '0;
                end
                default: state_d = PH_MODE;
            endcase
        end else if (mid) begin
            unique case (state_q)
                PH_MODE: if (mode_q != MODE_MAX) mode_d = mode_q + 2'd1;
                PH_REG:  if (sel_q != SEL_MAX)   sel_d  = sel_q + 1'b1;
                PH_BIT:  if (code_q != '1)       code_d = code_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign phase_o     = state_q;
    assign mode_o      = mode_q;
    assign sel_o       = sel_q;
    assign code_o      = code_q;
    assign code_step_o = !high && mid && (state_q == PH_BIT);
    assign code_next_o = code_d;
endmodule

// File: rtl/otp_blow_gate.sv
module otp_blow_gate
    import otp_prog_pkg::*;
#(
    parameter int W    = 3,
    parameter int NREG = 3,
    localparam int RW  = $clog2(NREG + 1)
) (
    input  phase_e        phase,
    input  logic [1:0]    mode,
    input  logic [RW-1:0] sel,
    input  logic [W-1:0]  code,
    input  logic          blow_req,
    input  logic          high,
    input  logic          mid,
    input  logic          code_step,
    input  logic          locked,
    output logic          blow_ok,
    output logic          blow_bad,
    output logic          try_wr
);
    logic eligible;

    always_comb begin
        eligible = blow_req && !high && !mid && (phase == PH_BIT)
                && (mode == MODE_BLOW) && !locked && (code != '0);
        blow_ok  = eligible && $onehot(code);
        blow_bad = eligible && !$onehot(code);
        try_wr   = code_step && (mode == MODE_TRY) && !locked
                && (sel < RW'(NREG));
    end
endmodule

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank #(
    parameter int W    = 3,
    parameter int NREG = 3,
    localparam int RW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            init_n,
    input  logic            por_n,
    input  logic [RW-1:0]   sel,
    input  logic [W-1:0]    code,
    input  logic [W-1:0]    try_code,
    input  logic            blow_ok,
    input  logic            blow_bad,
    input  logic            try_wr,
    output logic [NREG*W-1:0] fuse_flat,
    output logic [NREG*W-1:0] eff_flat,
    output logic            locked_o,
    output logic            err_o
);
    logic vol_rst;
    assign vol_rst = !init_n || !por_n;

    always_ff @(posedge clk) begin
        if (!init_n)                            locked_o <= 1'b0;
        else if (blow_ok && sel == RW'(NREG))   locked_o <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (vol_rst) err_o <= 1'b0;
        else         err_o <= blow_bad;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [W-1:0] fuse_q, try_q;
        logic         tried_q;

        always_ff @(posedge clk) begin
            if (!init_n)                        fuse_q <= '0;
            else if (blow_ok && sel == RW'(g))  fuse_q <= fuse_q | code;
        end

        always_ff @(posedge clk) begin
            if (vol_rst) begin
                try_q   <= '0;
                tried_q <= 1'b0;
            end else if (try_wr && sel == RW'(g)) begin
                try_q   <= try_code;
                tried_q <= 1'b1;
            end
        end

        assign fuse_flat[g*W +: W] = fuse_q;
        assign eff_flat[g*W +: W]  = tried_q ? try_q : fuse_q;
    end
endmodule

// File: rtl/otp_pulse_prog.sv
module otp_pulse_prog
    import otp_prog_pkg::*;
#(
    parameter int W    = 3,
    parameter int NREG = 3,
    localparam int RW  = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              fuse_init_n,
    input  logic              por_n,
    input  logic              mid_pulse,
    input  logic              high_pulse,
    input  logic              blow_req,
    output logic [1:0]        phase,
    output logic [NREG*W-1:0] eff_val,
    output logic              locked,
    output logic              blow_err
);
    phase_e        ph;
    logic [1:0]    mode;
    logic [RW-1:0] sel;
    logic [W-1:0]  code, code_next;
    logic          code_step, blow_ok, blow_bad, try_wr;
    logic [NREG*W-1:0] fuse_vec;

    otp_sel_fsm #(.W(W), .NREG(NREG)) u_fsm (
        .clk         (clk),
        .rst_n       (fuse_init_n && por_n),
        .mid         (mid_pulse),
        .high        (high_pulse),
        .phase_o     (ph),
        .mode_o      (mode),
        .sel_o       (sel),
        .code_o      (code),
        .code_step_o (code_step),
        .code_next_o (code_next)
    );

    otp_blow_gate #(.W(W), .NREG(NREG)) u_gate (
        .phase     (ph),
        .mode      (mode),
        .sel       (sel),
        .code      (code),
        .blow_req  (blow_req),
        .high      (high_pulse),
        .mid       (mid_pulse),
        .code_step (code_step),
        .locked    (locked),
        .blow_ok   (blow_ok),
        .blow_bad  (blow_bad),
        .try_wr    (try_wr)
    );

    otp_fuse_bank #(.W(W), .NREG(NREG)) u_bank (
        .clk       (clk),
        .init_n    (fuse_init_n),
        .por_n     (por_n),
        .sel       (sel),
        .code      (code),
        .try_code  (code_next),
        .blow_ok   (blow_ok),
        .blow_bad  (blow_bad),
        .try_wr    (try_wr),
        .fuse_flat (fuse_vec),
        .eff_flat  (eff_val),
        .locked_o  (locked),
        .err_o     (blow_err)
    );

    assign phase = ph;
endmodule

// File: rtl/otp_pulse_prog_chk.sv
module otp_pulse_prog_chk #(
    parameter int W    = 3,
    parameter int NREG = 3
) (
    input logic              clk,
    input logic              fuse_init_n,
    input logic              por_n,
    input logic              high_pulse,
    input logic [1:0]        phase,
    input logic [NREG*W-1:0] fuse_vec,
    input logic              locked,
    input logic              blow_err
);
    p_adv_reg_r1: assert property (@(posedge clk) disable iff (!fuse_init_n || !por_n)
        (high_pulse && phase == 2'd0) |=> (phase == 2'd1));
    p_adv_bit_r1: assert property (@(posedge clk) disable iff (!fuse_init_n || !por_n)
        (high_pulse && phase == 2'd1) |=> (phase == 2'd2));
    p_wrap_r1: assert property (@(posedge clk) disable iff (!fuse_init_n || !por_n)
        (high_pulse && phase == 2'd2) |=> (phase == 2'd0));
    p_legal_phase_r1: assert property (@(posedge clk) disable iff (!fuse_init_n)
        phase != 2'd3);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!fuse_init_n)
        1'b1 |=> ((fuse_vec & $past(fuse_vec)) == $past(fuse_vec)));
    p_one_bit_r4: assert property (@(posedge clk) disable iff (!fuse_init_n)
        (fuse_vec != $past(fuse_vec)) |-> ($countones(fuse_vec ^ $past(fuse_vec)) == 1));
    p_err_no_change_r5: assert property (@(posedge clk) disable iff (!fuse_init_n || !por_n)
        blow_err |-> $stable(fuse_vec));
    p_lock_freeze_r9: assert property (@(posedge clk) disable iff (!fuse_init_n)
        locked |=> ($stable(fuse_vec) && locked));
endmodule

bind otp_pulse_prog otp_pulse_prog_chk #(.W(W), .NREG(NREG)) u_chk (
    .clk         (clk),
    .fuse_init_n (fuse_init_n),
    .por_n       (por_n),
    .high_pulse  (high_pulse),
    .phase       (phase),
    .fuse_vec    (fuse_vec),
    .locked      (locked),
    .blow_err    (blow_err)
);

// File: tb/test_otp_pulse_prog.sv
module test_otp_pulse_prog;
    logic       clk = 1'b0;
    logic       fuse_init_n, por_n, mid_pulse, high_pulse, blow_req;
    logic [1:0] phase;
    logic [8:0] eff_val;
    logic       locked, blow_err;

    int checks = 0;
    int failures = 0;
    int fz[3] = '{0, 0, 0};

    always #2.5 clk = ~clk;

    otp_pulse_prog i_otp_pulse_prog (
        .clk(clk), .fuse_init_n(fuse_init_n), .por_n(por_n),
        .mid_pulse(mid_pulse), .high_pulse(high_pulse), .blow_req(blow_req),
        .phase(phase), .eff_val(eff_val), .locked(locked), .blow_err(blow_err)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic strobe(input logic h, input logic m, input logic b);
        @(negedge clk);
        high_pulse = h; mid_pulse = m; blow_req = b;
        @(negedge clk);
        high_pulse = 0; mid_pulse = 0; blow_req = 0;
    endtask

    task automatic mids(input int n);
        for (int i = 0; i < n; i++) strobe(0, 1, 0);
    endtask

    task automatic nav(input int m, input int r, input int c);
        mids(m); strobe(1, 0, 0); mids(r); strobe(1, 0, 0); mids(c);
    endtask

    task automatic power_cycle();
        @(negedge clk); por_n = 0;
        @(negedge clk); @(negedge clk); por_n = 1;
        @(negedge clk);
    endtask

    function automatic int slice(input int r);
        return int'((eff_val >> (3 * r)) & 9'd7);
    endfunction

    function automatic int fuse_pack();
        return fz[0] | (fz[1] << 3) | (fz[2] << 6);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        fuse_init_n = 0; por_n = 0; mid_pulse = 0; high_pulse = 0; blow_req = 0;
        repeat (3) @(negedge clk);
        fuse_init_n = 1; por_n = 1;
        @(negedge clk);
        check("R11 reset phase", phase, 0);
        check("R11 reset eff", eff_val, 0);
        check("R11 reset locked", locked, 0);
        check("R11 reset err", blow_err, 0);

        strobe(1, 0, 0); check("R1 mode->reg", phase, 1);
        strobe(1, 0, 0); check("R1 reg->bit", phase, 2);
        strobe(1, 0, 0); check("R1 bit->mode", phase, 0);

        // R3 / R2: sweep every trial code on every register, past saturation
        for (int r = 0; r < 3; r++) begin
            nav(2, r, 0);
            for (int c = 1; c <= 9; c++) begin
                strobe(0, 1, 0);
                check($sformatf("R3 R2 try reg%0d step%0d", r, c), slice(r), (c > 7) ? 7 : c);
            end
            strobe(1, 0, 0);
        end
        // R1: wrap cleared the code counter
        nav(2, 0, 0); strobe(0, 1, 0);
        check("R1 code cleared on wrap", slice(0), 1);
        strobe(1, 0, 0);

        // R10: high with mid and blow together -> only the advance
        nav(2, 1, 0);
        strobe(1, 1, 1);
        check("R10 high wins phase", phase, 0);
        check("R10 high wins value", slice(1), 7);

        power_cycle();
        check("R8 por phase", phase, 0);
        check("R8 por clears trials", eff_val, fuse_pack());

        nav(1, 1, 4); strobe(0, 0, 1); fz[1] |= 4;
        check("R4 blow bit2", slice(1), 4);
        check("R4 no err", blow_err, 0);
        strobe(1, 0, 0);

        nav(1, 1, 3); strobe(0, 0, 1);
        check("R5 err raised", blow_err, 1);
        check("R5 no change", slice(1), 4);
        @(negedge clk);
        check("R5 err one cycle", blow_err, 0);
        strobe(1, 0, 0);

        nav(1, 0, 0); strobe(0, 0, 1);
        check("R6 code0 no err", blow_err, 0);
        check("R6 code0 no change", slice(0), 0);
        strobe(1, 0, 0);
        nav(2, 2, 2); strobe(0, 0, 1);
        check("R6 try mode no err", blow_err, 0);
        strobe(1, 0, 0);
        strobe(0, 1, 0); strobe(1, 0, 0); strobe(0, 1, 0); strobe(0, 0, 1);
        check("R6 reg phase no err", blow_err, 0);
        strobe(1, 0, 0); strobe(1, 0, 0);
        power_cycle();
        check("R6 try/reg-phase blow left fuses", eff_val, fuse_pack());

        nav(1, 2, 2); strobe(0, 0, 1); strobe(1, 0, 0);
        nav(1, 2, 1); strobe(0, 0, 1); strobe(1, 0, 0); fz[2] = 3;
        check("R7 bit1 then bit0", slice(2), 3);
        nav(1, 0, 4); strobe(0, 0, 1); strobe(1, 0, 0);
        nav(1, 0, 1); strobe(0, 0, 1); strobe(1, 0, 0); fz[0] = 5;
        check("R7 bit2 then bit0", slice(0), 5);
        nav(1, 0, 4); strobe(0, 0, 1); strobe(1, 0, 0);
        check("R7 reblow no change", slice(0), 5);
        power_cycle();
        check("R7 fuses survive por", eff_val, fuse_pack());

        nav(5, 0, 0); mids(2);
        check("R2 mode key saturates to try", slice(0), 2);
        strobe(1, 0, 0);
        nav(2, 7, 0); mids(1);
        check("R2 reg saturates to lock reg", eff_val, 2 | (fz[1] << 3) | (fz[2] << 6));
        strobe(1, 0, 0);
        power_cycle();

        nav(2, 1, 0); mids(2);
        check("R3 trial overrides fuse", slice(1), 2);
        strobe(1, 0, 0);
        power_cycle();
        check("R8 fuse restored", slice(1), 4);

        nav(1, 3, 2); strobe(0, 0, 1);
        check("R4 lock set", locked, 1);
        strobe(1, 0, 0);
        nav(1, 1, 2); strobe(0, 0, 1);
        check("R9 blow ignored", slice(1), 4);
        strobe(1, 0, 0);
        nav(1, 1, 3); strobe(0, 0, 1);
        check("R6 locked bad code no err", blow_err, 0);
        strobe(1, 0, 0);
        nav(2, 0, 0); mids(3);
        check("R9 try ignored", slice(0), 5);
        strobe(1, 0, 0);
        power_cycle();
        check("R8 lock kept", locked, 1);
        check("R8 final eff", eff_val, fuse_pack());

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule